// File: doc/BRIEF.md
# I2C Register-Window Slave with Typed Address Ranges

This block is the serial front end of a peripheral that exposes an 8-bit register space to a host over I2C. The host addresses the slave for writing and sends one pointer byte, which selects the target for any data bytes that follow. A transfer that carries only the pointer byte sets up a later read. A read transfer starts at the current pointer. Each address range has its own access behaviour:

| Range | Behaviour |
|-------|-----------|
| 00h–4Bh | scratchpad storage, read/write, auto-incrementing |
| 60h | command register: the pointer does not advance on write |
| 61h | status byte, read-only |
| 62h | result byte, read-only |
| 67h | configuration byte, read/write |
| all other addresses | holes: writes are dropped, reads return FFh |

The first byte written to 60h in a transfer is a command code. Legal codes go to a one-cycle command strobe. Illegal codes are refused with a NACK. Every later byte written to 60h in the same transfer goes out as a parameter byte.

The bus lines are sampled by a system clock at least eight times faster than SCL. START and STOP are found from SDA edges while SCL is high. The protocol engine is one state machine with these states:

| State | Role | Exit |
|-------|------|------|
| IDLE | bus free | — |
| ADDR | shifts in the slave address | address match goes to ADDR_ACK; mismatch goes to IGNORE |
| ADDR_ACK | drives the address ACK | to PTR on a write; to RD on a read |
| PTR | shifts in the pointer byte | to PTR_ACK |
| PTR_ACK | drives the pointer ACK | to WR |
| WR | shifts in a data byte | an accepted byte goes to WR_ACK; a refused command code goes to IGNORE |
| WR_ACK | drives the data ACK | back to WR |
| RD | shifts a byte out | to RD_ACK |
| RD_ACK | samples the host's acknowledge | host ACK goes back to RD; host NACK goes to IGNORE |
| IGNORE | stays off the bus | — |

STOP sends any state to IDLE. START sends any state to ADDR.

Top module: `i2c_regwin_slave`

## Requirements
- R1: After reset the slave does not pull SDA low, and every scratchpad byte reads 00h.
- R2: The slave ACKs a START followed by its own 7-bit address (3Ah by default; bit 0 of the address byte is 1 for read and 0 for write). After any other address it never pulls SDA low until the next START or STOP.
- R3: In a write transfer, the byte after the address byte loads the pointer. Later bytes to addresses 00h–4Bh are ACKed, stored, and advance the pointer by one.
- R4: A read transfer returns bytes starting at the current pointer and advances the pointer after each byte. The pointer persists across transfers, so a write of only the pointer byte sets the read position.
- R5: The first byte written to 60h in a transfer is the command code. If it is one of 2Dh, 5Ah, A5h or F0h, it is ACKed and produces one cmd_valid pulse with cmd_param=0. Each later byte to 60h in the same transfer is ACKed and produces a pulse with cmd_param=1. The pointer stays at 60h throughout.
- R6: Any other command code is NACKed and produces no pulse. The slave then stays off the bus until a new START. The pointer is left at 60h.
- R7: After a legal command code, the pointer moves to 61h at the next START or STOP, so a read without a new pointer returns the status byte first.
- R8: A read at 60h returns FFh, and the pointer still advances to 61h.
- R9: 61h returns status_in and 62h returns result_in. Writes to 61h and 62h are ACKed and have no effect. 67h is a read/write configuration byte.
- R10: Holes (4Ch–5Fh, 63h–66h, 68h–FFh) ACK writes without storing them, return FFh on read, and advance the pointer.
- R11: After the host NACKs a read byte, the slave releases SDA and keeps it released until the next START or STOP.
- R12: A repeated START in the middle of a transfer returns the engine to the address phase, and the new transfer behaves like a fresh one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock, at least 8x SCL |
| rst_n | input | 1 | active-low asynchronous reset |
| scl_in | input | 1 | bus clock line, asynchronous |
| sda_in | input | 1 | bus data line as seen on the wire, asynchronous |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| status_in | input | 8 | value returned at 61h |
| result_in | input | 8 | value returned at 62h |
| cmd_valid | output | 1 | one-cycle strobe for a command or parameter byte |
| cmd_param | output | 1 | 0 for a command code, 1 for a parameter byte |
| cmd_byte | output | 8 | byte carried by the strobe |

## Verification
Most internal errors in this block are visible at the ports within one byte time, either in the value of the next byte read back or in the ACK bit. A pointer that advances wrongly, or fails to advance, shows up in the first data byte of the next read. An access-type decode that is off by one address shows up as FFh where stored data was expected, or the reverse, at the range boundaries. A wrong refusal decision shows up in the ninth-bit ACK and in the command strobe stream, which a scoreboard compares against an expected queue. A protocol state that is out of step would misalign every later bit, so it is exposed within the same transfer.

// File: rtl/i2c_regwin_pkg.sv
package i2c_regwin_pkg;

    localparam int unsigned AW = 8;

    localparam logic [AW-1:0] SCRATCH_LAST = 8'h4B;
    localparam logic [AW-1:0] CMD_ADDR     = 8'h60;
    localparam logic [AW-1:0] STAT_ADDR    = 8'h61;
    localparam logic [AW-1:0] RES_ADDR     = 8'h62;
    localparam logic [AW-1:0] CFG_ADDR     = 8'h67;

    typedef enum logic [2:0] {
        ACC_SCRATCH,
        ACC_CMD,
        ACC_STAT,
        ACC_RES,
        ACC_CFG,
        ACC_HOLE
    } acc_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_IGNORE
    } bus_st_e;

    function automatic acc_e addr_kind(input logic [AW-1:0] a);
        if (a <= SCRATCH_LAST)   return ACC_SCRATCH;
        else if (a == CMD_ADDR)  return ACC_CMD;
        else if (a == STAT_ADDR) return ACC_STAT;
        else if (a == RES_ADDR)  return ACC_RES;
        else if (a == CFG_ADDR)  return ACC_CFG;
        else                     return ACC_HOLE;
    endfunction

    function automatic logic cmd_legal(input logic [7:0] c);
        return (c == 8'h2D) || (c == 8'h5A) || (c == 8'hA5) || (c == 8'hF0);
    endfunction

endpackage

// File: rtl/i2c_regwin_sync.sv
module i2c_regwin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sr, sda_sr;
    logic              scl_d, sda_d;
    logic              scl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_in};
            sda_sr <= {sda_sr[STAGES-2:0], sda_in};
            scl_d  <= scl_sr[STAGES-1];
            sda_d  <= sda_sr[STAGES-1];
        end
    end

    assign scl_q     = scl_sr[STAGES-1];
    assign sda_q     = sda_sr[STAGES-1];
    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    assign start_det = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c_regwin_store.sv
module i2c_regwin_store
    import i2c_regwin_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 76
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            cfg_q <= '0;
        end else if (we) begin
            if (waddr == CFG_ADDR)            cfg_q <= wdata;
            else if (32'(waddr) < DEPTH)      mem[waddr] <= wdata;
        end
    end

    always_comb begin
        if (raddr == CFG_ADDR)           rdata = cfg_q;
        else if (32'(raddr) < DEPTH)     rdata = mem[raddr];
        else                             rdata = '1;
    end

    // R10: only scratchpad or configuration addresses may ever be stored
    a_r10_store_only_writable: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr <= SCRATCH_LAST || waddr == CFG_ADDR));
endmodule

// File: rtl/i2c_regwin_slave.sv
module i2c_regwin_slave
    import i2c_regwin_pkg::*;
#(
    parameter logic [6:0]  SLAVE_ADDR    = 7'h3A,
    parameter int unsigned DW            = 8,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned SCRATCH_DEPTH = 76
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_pull,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] result_in,
    output logic          cmd_valid,
    output logic          cmd_param,
    output logic [DW-1:0] cmd_byte
);
    localparam int unsigned BCW = $clog2(DW + 1);

    logic sda_q, scl_rise, scl_fall, start_det, stop_det;

    i2c_regwin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    bus_st_e        state_q, state_d;
    logic [BCW-1:0] bitcnt_q;
    logic [DW-1:0]  shreg_q, txreg_q;
    logic [AW-1:0]  ptr_q;
    logic           rw_q, host_ack_q, cmd_seen_q, cmd_pend_q;

    logic           bit_full, addr_hit, wr_refuse;
    acc_e           kind;
    logic [DW-1:0]  st_rdata, rd_byte;
    logic           st_we;

    assign bit_full  = (bitcnt_q == BCW'(DW));
    assign addr_hit  = (shreg_q[DW-1:1] == SLAVE_ADDR);
    assign kind      = addr_kind(ptr_q);
    assign wr_refuse = (kind == ACC_CMD) && !cmd_seen_q && !cmd_legal(shreg_q);
    assign st_we     = (state_q == ST_WR) && scl_fall && bit_full &&
                       (kind == ACC_SCRATCH || kind == ACC_CFG);

    i2c_regwin_store #(.DW(DW), .DEPTH(SCRATCH_DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(ptr_q), .wdata(shreg_q),
        .raddr(ptr_q), .rdata(st_rdata)
    );

    always_comb begin
        unique case (kind)
            ACC_SCRATCH, ACC_CFG: rd_byte = st_rdata;
            ACC_STAT:             rd_byte = status_in;
            ACC_RES:              rd_byte = result_in;
            default:              rd_byte = '1;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det)       state_d = ST_IDLE;
        else if (start_det) state_d = ST_ADDR;
        else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (scl_fall && bit_full) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_d = rw_q ? ST_RD : ST_PTR;
                ST_PTR:      if (scl_fall && bit_full) state_d = ST_PTR_ACK;
                ST_PTR_ACK:  if (scl_fall) state_d = ST_WR;
                ST_WR:       if (scl_fall && bit_full) state_d = wr_refuse ? ST_IGNORE : ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR;
                ST_RD:       if (scl_fall && bit_full) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = host_ack_q ? ST_RD : ST_IGNORE;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q   <= '0;
            shreg_q    <= '0;
            txreg_q    <= '0;
            ptr_q      <= '0;
            rw_q       <= 1'b0;
            host_ack_q <= 1'b0;
            cmd_seen_q <= 1'b0;
            cmd_pend_q <= 1'b0;
            sda_pull   <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_param  <= 1'b0;
            cmd_byte   <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (start_det || stop_det) begin
                bitcnt_q <= '0;
                sda_pull <= 1'b0;
                if (cmd_pend_q) begin
                    ptr_q      <= STAT_ADDR;
                    cmd_pend_q <= 1'b0;
                end
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_PTR, ST_WR: begin
                        if (scl_rise) begin
                            shreg_q  <= {shreg_q[DW-2:0], sda_q};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (scl_fall && bit_full) begin
                            bitcnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_pull <= 1'b1;
                                    rw_q     <= shreg_q[0];
                                end
                            end else if (state_q == ST_PTR) begin
                                ptr_q      <= shreg_q;
                                cmd_seen_q <= 1'b0;
                                sda_pull   <= 1'b1;
                            end else if (kind == ACC_CMD) begin
                                if (!wr_refuse) begin
                                    sda_pull   <= 1'b1;
                                    cmd_valid  <= 1'b1;
                                    cmd_param  <= cmd_seen_q;
                                    cmd_byte   <= shreg_q;
                                    cmd_seen_q <= 1'b1;
                                    if (!cmd_seen_q) cmd_pend_q <= 1'b1;
                                end
                            end else begin
                                sda_pull <= 1'b1;
                                ptr_q    <= ptr_q + 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        if (rw_q) begin
                            txreg_q  <= rd_byte;
                            sda_pull <= ~rd_byte[DW-1];
                            ptr_q    <= ptr_q + 1'b1;
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                    ST_PTR_ACK, ST_WR_ACK: if (scl_fall) sda_pull <= 1'b0;
                    ST_RD: begin
                        if (scl_rise) bitcnt_q <= bitcnt_q + 1'b1;
                        else if (scl_fall) begin
                            if (bit_full) begin
                                bitcnt_q <= '0;
                                sda_pull <= 1'b0;
                            end else if (bitcnt_q != '0) begin
                                txreg_q  <= {txreg_q[DW-2:0], 1'b0};
                                sda_pull <= ~txreg_q[DW-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) host_ack_q <= ~sda_q;
                        else if (scl_fall && host_ack_q) begin
                            txreg_q  <= rd_byte;
                            sda_pull <= ~rd_byte[DW-1];
                            ptr_q    <= ptr_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: a free bus is never pulled
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_pull);
    // R11: once off the bus (host NACK, refusal, mismatch) SDA stays released
    a_r11_ignore_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_pull);
    // R5: every forwarded byte leaves the pointer parked on the command register
    a_r5_cmd_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (ptr_q == CMD_ADDR));
    // R5: the command strobe lasts one cycle
    a_r5_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R6: no illegal code is ever forwarded as a command
    a_r6_only_legal_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_param) |-> cmd_legal(cmd_byte));
    // R7: a pending command moves the pointer to status at the bus condition
    a_r7_status_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pend_q && (start_det || stop_det)) |=> (ptr_q == STAT_ADDR));
endmodule

// File: tb/tb_i2c_regwin_slave.sv
module tb_i2c_regwin_slave;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_pull, sda_line;
    logic [7:0] status_in = 8'h3C, result_in = 8'hC3;
    logic       cmd_valid, cmd_param;
    logic [7:0] cmd_byte;

    assign sda_line = sda_m & ~sda_pull;

    i2c_regwin_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .status_in(status_in), .result_in(result_in),
        .cmd_valid(cmd_valid), .cmd_param(cmd_param), .cmd_byte(cmd_byte)
    );

    int tests = 0, fails = 0;
    logic [7:0] rd_exp_q[$];
    logic [7:0] rd_got_q[$];
    string      rd_tag_q[$];
    logic [8:0] cmd_exp_q[$];
    string      cmd_tag_q[$];

    localparam logic [7:0] AW_BYTE = 8'h74;  // 3Ah, write
    localparam logic [7:0] AR_BYTE = 8'h75;  // 3Ah, read

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wt(10); scl_m = 1'b1; wt(20); scl_m = 1'b0; wt(10);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wt(10); scl_m = 1'b1; wt(10); b = sda_line; wt(10); scl_m = 1'b0; wt(10);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(10); scl_m = 1'b1; wt(10); sda_m = 1'b0; wt(10); scl_m = 1'b0; wt(10);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(10); scl_m = 1'b1; wt(10); sda_m = 1'b1; wt(20);
    endtask

    task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        check((a == 1'b0) == exp_ack, req, {31'd0, ~a}, {31'd0, exp_ack});
    endtask

    // driver: pushes the expected byte, then performs the read
    task automatic rd(input logic [7:0] exp, input bit host_ack, input string req);
        logic [7:0] d;
        logic       b;
        rd_exp_q.push_back(exp);
        rd_tag_q.push_back(req);
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(~host_ack);
        rd_got_q.push_back(d);
    endtask

    task automatic exp_cmd(input bit param, input logic [7:0] b, input string req);
        cmd_exp_q.push_back({param, b});
        cmd_tag_q.push_back(req);
    endtask

    // monitor: compares read bytes and command strobes against the queues
    initial begin
        forever begin
            @(negedge clk);
            if (rd_got_q.size() > 0) begin
                logic [7:0] g, e;
                string      t;
                g = rd_got_q.pop_front();
                e = rd_exp_q.pop_front();
                t = rd_tag_q.pop_front();
                check(g == e, t, {24'd0, g}, {24'd0, e});
            end
            if (rst_n && cmd_valid) begin
                if (cmd_exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected command strobe", {23'd0, cmd_param, cmd_byte}, 32'd0);
                end else begin
                    logic [8:0] e;
                    string      t;
                    e = cmd_exp_q.pop_front();
                    t = cmd_tag_q.pop_front();
                    check({cmd_param, cmd_byte} == e, t, {23'd0, cmd_param, cmd_byte}, {23'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        check(sda_pull == 1'b0, "R1 reset sda", {31'd0, sda_pull}, 32'd0);

        // R1/R4: reset contents via pointer-only write then read
        bus_start(); send(AW_BYTE, 1, "R2 own addr ack"); send(8'h00, 1, "R3 ptr ack");
        bus_start(); send(AR_BYTE, 1, "R2 read addr ack");
        rd(8'h00, 1, "R1 scratch reset 00"); rd(8'h00, 0, "R1 scratch reset 01");
        bus_stop();

        // R2: foreign address is ignored
        bus_start(); send(8'h54, 0, "R2 foreign addr nack");
        send(8'h00, 0, "R2 ignored byte not acked");
        bus_stop();

        // R3/R4: write with auto-increment, read back after dummy write
        bus_start(); send(AW_BYTE, 1, "R3 addr"); send(8'h10, 1, "R3 ptr");
        send(8'h11, 1, "R3 data0"); send(8'h22, 1, "R3 data1"); send(8'h33, 1, "R3 data2");
        bus_stop();
        bus_start(); send(AW_BYTE, 1, "R4 addr"); send(8'h10, 1, "R4 dummy ptr");
        bus_start(); send(AR_BYTE, 1, "R4 raddr");
        rd(8'h11, 1, "R4 read 10h"); rd(8'h22, 1, "R4 read 11h"); rd(8'h33, 0, "R4 read 12h");
        wt(5);
        check(sda_pull == 1'b0, "R11 released after host nack", {31'd0, sda_pull}, 32'd0);
        bit_out(1'b1);
        check(sda_pull == 1'b0, "R11 still released", {31'd0, sda_pull}, 32'd0);
        bus_stop();
        bus_start(); send(AR_BYTE, 1, "R4 raddr again");
        rd(8'h00, 0, "R4 pointer persisted at 13h");
        bus_stop();

        // R10: boundary between scratchpad and hole
        bus_start(); send(AW_BYTE, 1, "R10 addr"); send(8'h4A, 1, "R10 ptr");
        send(8'hAA, 1, "R10 4Ah"); send(8'hBB, 1, "R10 4Bh"); send(8'hCC, 1, "R10 hole write acked");
        bus_stop();
        bus_start(); send(AW_BYTE, 1, "R10 addr"); send(8'h4A, 1, "R10 ptr");
        bus_start(); send(AR_BYTE, 1, "R10 raddr");
        rd(8'hAA, 1, "R10 read 4Ah"); rd(8'hBB, 1, "R10 read 4Bh");
        rd(8'hFF, 1, "R10 hole 4Ch FF"); rd(8'hFF, 0, "R10 hole 4Dh FF");
        bus_stop();

        // R9: read-only bytes and config
        bus_start(); send(AW_BYTE, 1, "R9 addr"); send(8'h61, 1, "R9 ptr");
        send(8'h12, 1, "R9 write 61h acked"); send(8'h34, 1, "R9 write 62h acked");
        bus_stop();
        bus_start(); send(AW_BYTE, 1, "R9 addr"); send(8'h61, 1, "R9 ptr");
        bus_start(); send(AR_BYTE, 1, "R9 raddr");
        rd(8'h3C, 1, "R9 status"); rd(8'hC3, 0, "R9 result");
        bus_stop();
        bus_start(); send(AW_BYTE, 1, "R9 addr"); send(8'h67, 1, "R9 cfg ptr");
        send(8'h5E, 1, "R9 cfg write");
        bus_stop();
        bus_start(); send(AW_BYTE, 1, "R9 addr"); send(8'h66, 1, "R9 ptr 66h");
        bus_start(); send(AR_BYTE, 1, "R9 raddr");
        rd(8'hFF, 1, "R10 hole 66h"); rd(8'h5E, 1, "R9 cfg read"); rd(8'hFF, 0, "R10 hole 68h");
        bus_stop();

        // R5/R7: legal command with parameters, then read lands on status
        exp_cmd(1'b0, 8'hA5, "R5 command code");
        exp_cmd(1'b1, 8'h01, "R5 param 0");
        exp_cmd(1'b1, 8'h02, "R5 param 1");
        bus_start(); send(AW_BYTE, 1, "R5 addr"); send(8'h60, 1, "R5 ptr");
        send(8'hA5, 1, "R5 legal code acked"); send(8'h01, 1, "R5 param acked");
        send(8'h02, 1, "R5 param acked");
        bus_start(); send(AR_BYTE, 1, "R7 raddr");
        rd(8'h3C, 1, "R7 status first"); rd(8'hC3, 1, "R7 result next"); rd(8'hFF, 0, "R10 hole 63h");
        bus_stop();

        // R6: illegal command refused, pointer stays 60h
        bus_start(); send(AW_BYTE, 1, "R6 addr"); send(8'h60, 1, "R6 ptr");
        send(8'h77, 0, "R6 illegal code nacked");
        send(8'h5A, 0, "R6 later byte ignored");
        bus_stop();
        bus_start(); send(AR_BYTE, 1, "R6 raddr");
        rd(8'hFF, 1, "R6 pointer left at 60h"); rd(8'h3C, 0, "R6 then status");
        bus_stop();

        // R8: incrementing read through the command register
        bus_start(); send(AW_BYTE, 1, "R8 addr"); send(8'h5F, 1, "R8 ptr");
        bus_start(); send(AR_BYTE, 1, "R8 raddr");
        rd(8'hFF, 1, "R8 hole 5Fh"); rd(8'hFF, 1, "R8 60h reads FF");
        rd(8'h3C, 1, "R8 advanced to 61h"); rd(8'hC3, 0, "R8 62h");
        bus_stop();

        // R12: repeated START in mid-write
        bus_start(); send(AW_BYTE, 1, "R12 addr"); send(8'h20, 1, "R12 ptr");
        send(8'h9A, 1, "R12 data");
        bus_start(); send(AW_BYTE, 1, "R12 restart addr"); send(8'h21, 1, "R12 new ptr");
        send(8'h9B, 1, "R12 data");
        bus_stop();
        bus_start(); send(AW_BYTE, 1, "R12 addr"); send(8'h20, 1, "R12 ptr");
        bus_start(); send(AR_BYTE, 1, "R12 raddr");
        rd(8'h9A, 1, "R12 first"); rd(8'h9B, 0, "R12 second");
        bus_stop();

        wt(20);
        check(cmd_exp_q.size() == 0, "R5 all commands seen", cmd_exp_q.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule